// File: doc/BRIEF.md
# Programmable Reed-Solomon Encoder

This block is a systematic Reed-Solomon encoder over GF(2^8). Bytes enter as a stream with a valid strobe and a start-of-block marker. The first K bytes of each block leave unchanged, and 2t parity symbols follow immediately after them. Both the correction strength t and the message length K are set at run time through a small configuration port.

Each configuration load rebuilds the generator polynomial in hardware. The block multiplies together the first-degree factors with consecutive roots, one factor per clock. While that build runs, and while parity leaves the block, the input stream is held off with a ready signal. When encoding is switched off, or when t is zero, the block acts as a one-cycle register stage: bytes pass through and no parity is added.

Top module: `rsenc_top`

## Requirements
- R1: All symbol products use GF(2^8) reduced by x^8 + x^4 + x^3 + x^2 + 1 (0x11D), with alpha = 0x02.
- R2: A pulse on `cfg_load` starts a build of g(x) = (x + alpha^0)(x + alpha^1)...(x + alpha^(2t-1)) that takes 2t clock cycles. During those cycles `in_ready` is low.
- R3: `cfg_t` selects t from 0 to 10. Any larger value is treated as 10, giving 20 parity symbols.
- R4: `cfg_k` gives the message length K, from 16 to 255 - 2t, so the block length K + 2t never exceeds 255. The longest block, with K = 235 and t = 10, is supported.
- R5: `cfg_en` = 0 disables encoding regardless of t.
- R6: When encoding is disabled or t = 0, every accepted byte appears on `out_data` one cycle later, unchanged, with `out_parity` = 0. No parity bytes are produced.
- R7: When encoding is on, the K-th accepted message byte of a block is followed on the next 2t consecutive cycles by parity bytes with `out_parity` = 1. `in_ready` is low for exactly those 2t cycles.
- R8: The output is systematic. Each accepted message byte appears unchanged on `out_data` one cycle after acceptance. Parity is sent from the highest-degree remainder coefficient down to the lowest, so the emitted block, read first byte as the highest power, evaluates to zero at alpha^0 through alpha^(2t-1).
- R9: A byte accepted with `in_sob` = 1 clears the remainder and restarts the message count. This holds even in the middle of an unfinished block.
- R10: `out_sob` is 1 exactly on the output byte whose input carried `in_sob` = 1.
- R11: After reset, `in_ready` = 1, `out_valid` = 0, and the configuration is t = 0 with encoding disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load configuration and start generator build |
| cfg_t | input | 4 | Correction strength t (clamped to 10) |
| cfg_k | input | 8 | Message length K in bytes |
| cfg_en | input | 1 | Encoding enable |
| in_valid | input | 1 | Input byte valid |
| in_sob | input | 1 | Input byte is first of a block |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block can take an input byte this cycle |
| out_valid | output | 1 | Output byte valid |
| out_sob | output | 1 | Output byte is first of a block |
| out_parity | output | 1 | Output byte is a parity symbol |
| out_data | output | 8 | Output byte |

## Verification
The assertions assume that every block starts with a byte marked `in_sob`. They also assume that `cfg_load` is pulsed only while the stream is idle, with K inside the legal range for the chosen t. The stimulus follows these rules in three ways:
- The driver issues configuration only between blocks.
- The driver always sets the start marker on the first byte of a block.
- The driver offers a byte only after seeing `in_ready` high.

Partial blocks are always cut short by a fresh start marker rather than by a configuration change.

// File: rtl/rsenc_pkg.sv
package rsenc_pkg;
  localparam int SYM_W = 8;
  localparam logic [SYM_W:0] FIELD_POLY = 9'h11D;
  typedef logic [SYM_W-1:0] sym_t;

  function automatic sym_t gf_mul(sym_t a, sym_t b);
    sym_t acc;
    sym_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      if (sh[SYM_W-1]) sh = (sh << 1) ^ FIELD_POLY[SYM_W-1:0];
      else             sh = sh << 1;
    end
    return acc;
  endfunction
endpackage

// File: rtl/rsenc_genpoly.sv
module rsenc_genpoly
  import rsenc_pkg::*;
#(
  parameter int T_MAX = 10,
  localparam int NR = 2 * T_MAX,
  localparam int CW = $clog2(NR + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CW-1:0]     nroots_in,
  output logic              busy,
  output sym_t [NR:0]       coef
);
  sym_t          root;
  logic [CW-1:0] step;
  logic [CW-1:0] goal;
  sym_t [NR:0]   coef_nx;

  // multiply current polynomial by (x + root)
  always_comb begin
    for (int j = 0; j <= NR; j++) begin
      coef_nx[j] = gf_mul(coef[j], root);
      if (j > 0) coef_nx[j] = coef_nx[j] ^ coef[j-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      coef    <= '0;
      coef[0] <= 8'h01;
      root    <= 8'h01;
      step    <= '0;
      goal    <= '0;
      busy    <= 1'b0;
    end else if (load) begin
      coef    <= '0;
      coef[0] <= 8'h01;
      root    <= 8'h01;
      step    <= '0;
      goal    <= nroots_in;
      busy    <= (nroots_in != '0);
    end else if (busy) begin
      coef <= coef_nx;
      root <= gf_mul(root, 8'h02);
      step <= step + 1'b1;
      if (step == goal - 1'b1) busy <= 1'b0;
    end
  end

  a_r2_monic_after_build: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (coef[goal] == 8'h01));
  a_r2_build_starts: assert property (@(posedge clk) disable iff (rst)
    (load && nroots_in != '0) |=> busy);
endmodule

// File: rtl/rsenc_parity.sv
module rsenc_parity
  import rsenc_pkg::*;
#(
  parameter int T_MAX = 10,
  localparam int NR = 2 * T_MAX,
  localparam int CW = $clog2(NR + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd,
  input  logic          clr,
  input  logic          shift,
  input  sym_t          din,
  input  logic [CW-1:0] nroots,
  input  sym_t [NR:0]   coef,
  output sym_t          top_sym
);
  sym_t [NR-1:0] rem;
  sym_t [NR-1:0] base;
  sym_t [NR-1:0] rem_nx;
  logic [CW-1:0] top_idx;
  sym_t          fb;

  always_comb begin
    top_idx = (nroots == '0) ? '0 : nroots - 1'b1;
    base    = clr ? '0 : rem;
    fb      = din ^ base[top_idx];
    for (int j = 0; j < NR; j++) begin
      rem_nx[j] = gf_mul(fb, coef[j]);
      if (j > 0) rem_nx[j] = rem_nx[j] ^ base[j-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rem <= '0;
    else if (upd)   rem <= rem_nx;
    else if (shift) rem <= {rem[NR-2:0], sym_t'(0)};
  end

  assign top_sym = rem[top_idx];

  a_r9_sob_clears: assert property (@(posedge clk) disable iff (rst)
    (upd && clr && din == 8'h00) |=> (rem == '0));
endmodule

// File: rtl/rsenc_ctrl.sv
module rsenc_ctrl #(
  parameter int T_MAX = 10,
  localparam int NR = 2 * T_MAX,
  localparam int CW = $clog2(NR + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_sob,
  input  logic          busy,
  input  logic          bypass,
  input  logic [7:0]    k_len,
  input  logic [CW-1:0] nroots,
  output logic          in_ready,
  output logic          accept,
  output logic          upd,
  output logic          par
);
  logic [7:0]    cnt;
  logic [7:0]    cnt_nx;
  logic [CW-1:0] pcnt;

  assign in_ready = !busy && !par;
  assign accept   = in_valid && in_ready;
  assign upd      = accept && !bypass;
  assign cnt_nx   = in_sob ? 8'd1 : cnt + 8'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      par  <= 1'b0;
      cnt  <= '0;
      pcnt <= '0;
    end else begin
      if (upd) begin
        if (cnt_nx == k_len) begin
          cnt  <= '0;
          par  <= 1'b1;
          pcnt <= '0;
        end else begin
          cnt <= cnt_nx;
        end
      end
      if (par) begin
        pcnt <= pcnt + 1'b1;
        if (pcnt == nroots - 1'b1) par <= 1'b0;
      end
    end
  end

  a_r7_parity_run_bounded: assert property (@(posedge clk) disable iff (rst)
    par |-> (pcnt < nroots));
endmodule

// File: rtl/rsenc_top.sv
module rsenc_top
  import rsenc_pkg::*;
#(
  parameter int T_MAX = 10,
  localparam int NR = 2 * T_MAX,
  localparam int CW = $clog2(NR + 1),
  localparam int TW = $clog2(T_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_load,
  input  logic [TW-1:0] cfg_t,
  input  logic [7:0]    cfg_k,
  input  logic          cfg_en,
  input  logic          in_valid,
  input  logic          in_sob,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic          out_sob,
  output logic          out_parity,
  output logic [7:0]    out_data
);
  logic [TW-1:0] t_clamp;
  logic [CW-1:0] nr_in;
  logic [CW-1:0] nroots_q;
  logic [7:0]    k_q;
  logic          en_q;
  logic          bypass;
  logic          busy;
  logic          accept;
  logic          upd;
  logic          par;
  sym_t [NR:0]   coef;
  sym_t          top_sym;

  always_comb begin
    t_clamp = (cfg_t > TW'(T_MAX)) ? TW'(T_MAX) : cfg_t;
    nr_in   = CW'(t_clamp);
    nr_in   = nr_in << 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nroots_q <= '0;
      k_q      <= '0;
      en_q     <= 1'b0;
    end else if (cfg_load) begin
      nroots_q <= nr_in;
      k_q      <= cfg_k;
      en_q     <= cfg_en;
    end
  end

  assign bypass = !en_q || (nroots_q == '0);

  rsenc_genpoly #(.T_MAX(T_MAX)) u_gen (
    .clk(clk), .rst(rst), .load(cfg_load), .nroots_in(nr_in),
    .busy(busy), .coef(coef)
  );

  rsenc_ctrl #(.T_MAX(T_MAX)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sob(in_sob),
    .busy(busy), .bypass(bypass), .k_len(k_q), .nroots(nroots_q),
    .in_ready(in_ready), .accept(accept), .upd(upd), .par(par)
  );

  rsenc_parity #(.T_MAX(T_MAX)) u_par (
    .clk(clk), .rst(rst), .upd(upd), .clr(in_sob), .shift(par),
    .din(in_data), .nroots(nroots_q), .coef(coef), .top_sym(top_sym)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sob    <= 1'b0;
      out_parity <= 1'b0;
      out_data   <= '0;
    end else begin
      out_valid  <= accept || par;
      out_sob    <= accept && in_sob;
      out_parity <= par;
      out_data   <= accept ? in_data : top_sym;
    end
  end

  a_r8_msg_unchanged: assert property (@(posedge clk) disable iff (rst)
    accept |=> (out_valid && out_data == $past(in_data) && !out_parity));
  a_r6_bypass_no_parity: assert property (@(posedge clk) disable iff (rst)
    (accept && bypass) |=> !par);
  a_r7_parity_holds_input: assert property (@(posedge clk) disable iff (rst)
    out_parity |-> !$past(in_ready));
  a_r10_sob_forward: assert property (@(posedge clk) disable iff (rst)
    (accept && in_sob) |=> out_sob);
endmodule

// File: tb/rsenc_top_tb.sv
module rsenc_top_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_load = 1'b0;
  logic [3:0] cfg_t = '0;
  logic [7:0] cfg_k = '0;
  logic       cfg_en = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_sob = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, out_valid, out_sob, out_parity;
  logic [7:0] out_data;

  int checks = 0;
  int fails  = 0;
  int exp_t[256];
  int log_t[256];
  int g[21];
  int cur_np = 0, cur_k = 0;
  bit cur_en = 0;
  int q_d[$];
  bit q_p[$];
  bit q_s[$];
  int cw[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rsenc_top u_dut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_t(cfg_t), .cfg_k(cfg_k),
    .cfg_en(cfg_en), .in_valid(in_valid), .in_sob(in_sob), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_sob(out_sob),
    .out_parity(out_parity), .out_data(out_data)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int gmul(int a, int b);
    if (a == 0 || b == 0) return 0;
    return exp_t[(log_t[a] + log_t[b]) % 255];
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q_d.size() == 0) begin
        chk(0, "R8", "unexpected output byte", out_data, -1);
      end else begin
        int ed; bit ep; bit es;
        ed = q_d.pop_front(); ep = q_p.pop_front(); es = q_s.pop_front();
        chk(out_data == 8'(ed), "R8", "output byte", out_data, ed);
        chk(out_parity == ep, "R7", "parity flag", out_parity, ep);
        chk(out_sob == es, "R10", "start flag", out_sob, es);
      end
      if (out_sob) cw.delete();
      cw.push_back(out_data);
    end
  end

  task automatic configure(int t, int k, bit en);
    int tc; int low;
    tc = (t > 10) ? 10 : t;
    cur_np = 2 * tc; cur_k = k; cur_en = en;
    for (int j = 0; j < 21; j++) g[j] = 0;
    g[0] = 1;
    for (int i = 0; i < cur_np; i++) begin
      for (int j = 20; j >= 0; j--)
        g[j] = gmul(g[j], exp_t[i]) ^ ((j > 0) ? g[j-1] : 0);
    end
    @(negedge clk);
    cfg_load = 1; cfg_t = 4'(t); cfg_k = 8'(k); cfg_en = en;
    @(negedge clk);
    cfg_load = 0;
    low = 0;
    while (!in_ready) begin low++; @(negedge clk); end
    chk(low == cur_np, (t > 10) ? "R3" : "R2", "build ready-low cycles", low, cur_np);
  endtask

  task automatic send(int n, bit full);
    int msg[];
    int buff[];
    int low; int np; bit enc;
    enc = cur_en && cur_np > 0;
    np = (enc && full) ? cur_np : 0;
    msg = new[n];
    for (int i = 0; i < n; i++) begin
      msg[i] = $urandom_range(0, 255);
      q_d.push_back(msg[i]); q_p.push_back(0); q_s.push_back(i == 0);
    end
    if (np > 0) begin
      buff = new[n + np];
      for (int i = 0; i < n + np; i++) buff[i] = (i < n) ? msg[i] : 0;
      for (int i = 0; i < n; i++) begin
        int c; c = buff[i];
        for (int j = 1; j <= np; j++) buff[i+j] ^= gmul(c, g[np-j]);
      end
      for (int i = 0; i < np; i++) begin
        q_d.push_back(buff[n+i]); q_p.push_back(1); q_s.push_back(0);
      end
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1; in_sob = (i == 0); in_data = 8'(msg[i]);
    end
    @(negedge clk);
    in_valid = 0; in_sob = 0;
    low = 0;
    while (!in_ready) begin low++; @(negedge clk); end
    chk(low == np, enc ? "R7" : "R6", "parity ready-low cycles", low, np);
    @(negedge clk);
    if (np > 0) begin
      chk(cw.size() == n + np, "R4", "block length", cw.size(), n + np);
      for (int i = 0; i < np; i++) begin
        int s; s = 0;
        foreach (cw[b]) s = gmul(s, exp_t[i]) ^ cw[b];
        chk(s == 0, "R8", "syndrome at alpha power", s, 0);
      end
    end
  endtask

  initial begin
    int v; v = 1;
    for (int i = 0; i < 255; i++) begin
      exp_t[i] = v; log_t[v] = i;
      v = v << 1;
      if (v & 256) v = v ^ 'h11D; // R1 field polynomial
    end
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(in_ready == 1, "R11", "ready after reset", in_ready, 1);
    chk(out_valid == 0, "R11", "valid after reset", out_valid, 0);
    send(10, 1);                 // R11 default bypass
    configure(2, 16, 1);  send(16, 1);
    configure(8, 40, 1);  send(40, 1); send(40, 1);
    configure(10, 235, 1); send(235, 1);   // R4 longest block
    configure(15, 20, 1); send(20, 1);     // R3 clamp
    configure(1, 16, 1);  send(16, 1);
    configure(4, 30, 0);  send(30, 1);     // R5 disabled
    configure(0, 16, 1);  send(20, 1);     // R6 t=0
    configure(3, 20, 1);  send(7, 0); send(20, 1);  // R9 restart mid-block
    repeat (3) @(negedge clk);
    chk(q_d.size() == 0, "R7", "scoreboard drained", q_d.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R7 watchdog expired: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule